// File: doc/BRIEF.md
# Command Launch Handshake Unit

This block sits between the host register file and a card-interface sequencer. Software writes a 32-bit command word. When the word carries the launch flag in bit 31, the unit keeps the word and offers it to the sequencer over a valid/ready handshake. On the cycle after the sequencer takes it, the unit clears the launch flag, so a software read shows that the command has left. When the sequencer later reports completion, the unit raises a one-cycle done pulse. That pulse is a command-done pulse for a normal command and an update-done pulse for a clock-settings-only request.

While the launch flag is still set, the command word is locked. Any write to it is dropped and raises a one-cycle locked-write error pulse, which the host maps onto interrupt status bit 12. Bit 13 asks the unit to hold the command while a data transfer is running. Bit 14 marks a stop/abort command, and such a command is offered even while data is moving. A word that sets both boot-start (bit 24) and boot-stop (bit 26) together with the launch flag is refused: the launch flag is cleared, nothing is offered, and a boot error pulse is raised. Only one command is with the sequencer at a time.

Top module: `cmd_launch_unit`

## Requirements
- R1: After reset the command word reads 0, `issueValid` is low, and all four pulse outputs are low.
- R2: An accepted write with bit 31 set is stored in full. Bit 31 reads back 1 until the cycle after `issueValid && seqReady`. Then it reads 0 while bits 30..0 keep the written value.
- R3: A write made while bit 31 reads 1 leaves bits 30..0 unchanged. In the next cycle it drives `lockErrPulse` high for exactly one cycle.
- R4: While a command with bit 13 = 1 and bit 14 = 0 is pending and `dataBusy` is high, `issueValid` stays low. It rises once `dataBusy` falls. With bit 13 = 0, the command is offered regardless of `dataBusy`.
- R5: A pending command with bit 14 (stop/abort) = 1 is offered even when bit 13 = 1 and `dataBusy` is high.
- R6: For a command with bit 21 = 0, `seqDone` while the command is in flight gives `cmdDonePulse` high for one cycle in the next cycle, and `clkUpdDonePulse` stays low.
- R7: For a command with bit 21 (clock update only) = 1, completion gives `clkUpdDonePulse` instead, and `cmdDonePulse` stays low.
- R8: A write with bits 31, 24 and 26 all set stores the word with bit 31 cleared and never raises `issueValid`. In the next cycle it pulses `bootErrPulse` for one cycle.
- R9: A write with bit 31 clear is stored as written and never raises `issueValid`.
- R10: After a handoff, `issueValid` stays low until `seqDone`, even if a new command is written in the meantime. The new command is offered in the cycle after `seqDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the command word |
| wrData | input | 32 | Command word to write |
| dataBusy | input | 1 | A data transfer is in progress |
| seqReady | input | 1 | Sequencer can take a command |
| seqDone | input | 1 | Sequencer finished the in-flight command |
| cmdWord | output | 32 | Current command word, including the launch flag |
| issueValid | output | 1 | Command is offered to the sequencer |
| cmdDonePulse | output | 1 | Normal command completed |
| clkUpdDonePulse | output | 1 | Clock update request completed |
| lockErrPulse | output | 1 | Write rejected because the command word is locked |
| bootErrPulse | output | 1 | Conflicting boot bits, command refused |

## Verification
The bench sweeps all sixteen combinations of wait-for-data, stop/abort, data busy and clock-only, and derives the expected hold and done kind arithmetically for each one.

Each corner case targets a specific fault:
- A design that ignores the abort bypass would leave stop commands stuck behind a transfer.
- A design that swaps the done kinds would raise a command-done interrupt for a clock update.
- A lock that overwrites the word would corrupt the in-flight fields without raising an error.
- A unit that forgets the in-flight state would offer a second command before the first completes.

The boot conflict and the start-less write are checked for the absence of any offer.

// File: rtl/cmd_launch_pkg.sv
package cmd_launch_pkg;
  localparam int WORD_W     = 32;
  localparam int START_POS  = 31;
  localparam int WAITD_POS  = 13;
  localparam int ABORT_POS  = 14;
  localparam int CLKUPD_POS = 21;
  localparam int BOOTON_POS = 24;
  localparam int BOOTOFF_POS = 26;

  typedef struct packed {
    logic load;       // take wrData into the word register
    logic loadStart;  // value given to the launch flag on load
    logic clearStart; // handoff done, drop the launch flag
  } strobe_t;
endpackage

// File: rtl/cmd_launch_dp.sv
module cmd_launch_dp
  import cmd_launch_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int SP = START_POS
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      strobe,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] word
);
  localparam int LOW_W = SP;

  logic [LOW_W-1:0] fieldReg;
  logic             startReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fieldReg <= '0;
      startReg <= 1'b0;
    end else if (strobe.load) begin
      fieldReg <= wrData[LOW_W-1:0];
      startReg <= strobe.loadStart;
    end else if (strobe.clearStart) begin
      startReg <= 1'b0;
    end
  end

  assign word = {startReg, fieldReg};

  // R2
  launch_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearStart && !strobe.load |=> !word[SP]);
endmodule

// File: rtl/cmd_launch_ctrl.sv
module cmd_launch_ctrl
  import cmd_launch_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  input  logic [W-1:0] word,
  input  logic         dataBusy,
  input  logic         seqReady,
  input  logic         seqDone,
  output strobe_t      strobe,
  output logic         issueValid,
  output logic         cmdDonePulse,
  output logic         clkUpdDonePulse,
  output logic         lockErrPulse,
  output logic         bootErrPulse
);
  logic inFlight;
  logic flightIsClk;
  logic pending;
  logic holdForData;
  logic writeOpen;
  logic bootConflict;
  logic handoff;

  assign pending      = word[START_POS];
  assign holdForData  = word[WAITD_POS] && !word[ABORT_POS] && dataBusy;
  assign writeOpen    = wrEn && !pending;
  assign bootConflict = wrData[START_POS] && wrData[BOOTON_POS] && wrData[BOOTOFF_POS];
  assign issueValid   = pending && !inFlight && !holdForData;
  assign handoff      = issueValid && seqReady;

  always_comb begin
    strobe.load       = writeOpen;
    strobe.loadStart  = wrData[START_POS] && !bootConflict;
    strobe.clearStart = handoff;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFlight        <= 1'b0;
      flightIsClk     <= 1'b0;
      cmdDonePulse    <= 1'b0;
      clkUpdDonePulse <= 1'b0;
      lockErrPulse    <= 1'b0;
      bootErrPulse    <= 1'b0;
    end else begin
      lockErrPulse    <= wrEn && pending;
      bootErrPulse    <= writeOpen && bootConflict;
      cmdDonePulse    <= inFlight && seqDone && !flightIsClk;
      clkUpdDonePulse <= inFlight && seqDone && flightIsClk;
      if (handoff) begin
        inFlight    <= 1'b1;
        flightIsClk <= word[CLKUPD_POS];
      end else if (seqDone) begin
        inFlight <= 1'b0;
      end
    end
  end

  // R3
  locked_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && word[START_POS] |=> lockErrPulse && word[W-2:0] == $past(word[W-2:0]));

  // R10
  single_flight_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && seqReady |=> !issueValid);

  // R8
  boot_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !word[START_POS] && bootConflict |=> bootErrPulse && !word[START_POS]);

  // R6
  done_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdDonePulse && clkUpdDonePulse));

  // R7
  done_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdDonePulse || clkUpdDonePulse |=> !cmdDonePulse && !clkUpdDonePulse);
endmodule

// File: rtl/cmd_launch_unit.sv
module cmd_launch_unit
  import cmd_launch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  input  logic        dataBusy,
  input  logic        seqReady,
  input  logic        seqDone,
  output logic [31:0] cmdWord,
  output logic        issueValid,
  output logic        cmdDonePulse,
  output logic        clkUpdDonePulse,
  output logic        lockErrPulse,
  output logic        bootErrPulse
);
  strobe_t strobe;

  cmd_launch_dp #(.W(WORD_W), .SP(START_POS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .word(cmdWord)
  );

  cmd_launch_ctrl #(.W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .word(cmdWord),
    .dataBusy(dataBusy), .seqReady(seqReady), .seqDone(seqDone),
    .strobe(strobe), .issueValid(issueValid), .cmdDonePulse(cmdDonePulse),
    .clkUpdDonePulse(clkUpdDonePulse), .lockErrPulse(lockErrPulse),
    .bootErrPulse(bootErrPulse)
  );
endmodule

// File: tb/cmd_launch_unit_tb.sv
module cmd_launch_unit_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic dataBusy = 1'b0;
  logic seqReady = 1'b0;
  logic seqDone = 1'b0;
  logic [31:0] cmdWord;
  logic issueValid, cmdDonePulse, clkUpdDonePulse, lockErrPulse, bootErrPulse;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  cmd_launch_unit u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .dataBusy(dataBusy),
    .seqReady(seqReady), .seqDone(seqDone), .cmdWord(cmdWord),
    .issueValid(issueValid), .cmdDonePulse(cmdDonePulse),
    .clkUpdDonePulse(clkUpdDonePulse), .lockErrPulse(lockErrPulse),
    .bootErrPulse(bootErrPulse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeWord(input logic [31:0] w);
    wrEn = 1'b1;
    wrData = w;
    tick();
    wrEn = 1'b0;
    wrData = '0;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] w;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 word", cmdWord, 32'h0);
    check("R1 pulses", {issueValid, cmdDonePulse, clkUpdDonePulse, lockErrPulse, bootErrPulse}, 0);
    rstN = 1'b1;
    tick();

    // Sweep: bit0 waitData, bit1 abort, bit2 dataBusy, bit3 clockOnly
    for (int c = 0; c < 16; c++) begin
      logic wd, ab, bz, ck, hold;
      wd = c[0]; ab = c[1]; bz = c[2]; ck = c[3];
      hold = wd && !ab && bz;
      w = 32'h8000_0000 | (32'(wd) << 13) | (32'(ab) << 14) | (32'(ck) << 21)
          | 32'h0000_0240 | 32'(c + 5);
      dataBusy = bz;
      writeWord(w);
      check("R2 stored", cmdWord, w);
      check(hold ? "R4 hold" : (ab ? "R5 abort bypass" : "R4 offer"), 32'(issueValid), 32'(!hold));
      seqReady = 1'b1;
      tick();
      seqReady = 1'b0;
      if (hold) begin
        check("R4 still pending", 32'(cmdWord[31]), 1);
        dataBusy = 1'b0;
        #1;
        check("R4 released", 32'(issueValid), 1);
        seqReady = 1'b1;
        tick();
        seqReady = 1'b0;
      end
      check("R2 launch cleared", cmdWord, {1'b0, w[30:0]});
      check("R10 no reissue", 32'(issueValid), 0);
      seqDone = 1'b1;
      tick();
      seqDone = 1'b0;
      check("R6 cmd done", 32'(cmdDonePulse), 32'(!ck));
      check("R7 clk done", 32'(clkUpdDonePulse), 32'(ck));
      tick();
      check("R6 R7 single pulse", 32'({cmdDonePulse, clkUpdDonePulse}), 0);
      dataBusy = 1'b0;
    end

    // R3 locked write
    seqReady = 1'b0;
    writeWord(32'h8000_0011);
    writeWord(32'h8000_0022);
    check("R3 lock pulse", 32'(lockErrPulse), 1);
    check("R3 word kept", cmdWord, 32'h8000_0011);
    tick();
    check("R3 pulse one cycle", 32'(lockErrPulse), 0);
    seqReady = 1'b1;
    tick();
    seqReady = 1'b0;

    // R10 new command written while the previous one is in flight
    writeWord(32'h8000_0033);
    check("R10 pending stored", cmdWord, 32'h8000_0033);
    check("R10 held in flight", 32'(issueValid), 0);
    seqDone = 1'b1;
    tick();
    seqDone = 1'b0;
    check("R10 offered after done", 32'(issueValid), 1);
    seqReady = 1'b1;
    tick();
    seqReady = 1'b0;
    seqDone = 1'b1;
    tick();
    seqDone = 1'b0;
    tick();

    // R8 conflicting boot bits
    w = 32'h8500_0007;
    writeWord(w);
    check("R8 boot err", 32'(bootErrPulse), 1);
    check("R8 word", cmdWord, {1'b0, w[30:0]});
    check("R8 not offered", 32'(issueValid), 0);
    tick();
    check("R8 pulse one cycle", 32'(bootErrPulse), 0);
    check("R8 lock quiet", 32'(lockErrPulse), 0);

    // R9 write without launch flag
    writeWord(32'h0020_6041);
    check("R9 stored", cmdWord, 32'h0020_6041);
    seqReady = 1'b1;
    tick();
    check("R9 not offered", 32'(issueValid), 0);
    check("R9 no done", 32'({cmdDonePulse, clkUpdDonePulse}), 0);
    seqReady = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule